// File: doc/BRIEF.md
# Virtualization Control Capability Checker

This block decides whether a proposed pair of virtual-machine execution control words may be used for a guest entry. It compares them with the capability words that describe the allowed settings. Each capability word is 64 bits wide. The low half marks the control bits that must be 1. The high half marks the control bits that may be 1. A control bit violates its capability if it is 0 where a 1 is required, or 1 where a 1 is not allowed.

Two encodings exist for the primary control word. A selector bit in the basic capability word picks between them. In the "true" encoding the primary word is judged only by the true capability word. In the legacy encoding the primary word is judged by the legacy capability word, and a fixed set of default-1 bits must also be 1.

The secondary control word is checked only when a gating bit in the primary word is set. It is then checked for forbidden 1s only.

A request is taken on a valid/ready handshake. One clock later the block presents a registered verdict with a response-valid pulse. The verdict holds a per-bit violation mask for each word, a flag for each word that failed, and an overall fail flag.

Top module: `vmctl_cap_check`

## Requirements
- R1: While `rst` is high, at the next clock `rsp_valid`, `req_ready`, both masks and all fail flags become 0. `req_ready` becomes 1 on the first clock with `rst` low.
- R2: A request is accepted on a clock where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 for exactly the following cycle. It is 0 after any clock without an accept, and the result outputs then keep their values.
- R3: Primary bit X is a violation (bit X of `rsp_pri_mask` = 1) when control bit X is 0 and bit X of the selected capability word is 1.
- R4: Primary bit X is a violation when control bit X is 1 and bit 32+X of the selected capability word is 0.
- R5: When bit 55 of `basic_cap` is 1, the selected capability word is `true_cap` and `legacy_cap` has no effect.
- R6: When bit 55 of `basic_cap` is 0, the selected capability word is `legacy_cap` and `true_cap` has no effect. In this mode the primary bits in mask 0x0401E172 (bits 1, 4-6, 8, 13-16, 26) are also required to be 1.
- R7: When bit 55 of `basic_cap` is 1, the default-1 bits carry no extra requirement: a 0 there fails only if `true_cap` requires it.
- R8: With gating on, secondary bit X is a violation exactly when `sec_ctl` bit X is 1 and `sec_cap` bit 32+X is 0. `sec_cap[31:0]` has no effect, and a 0 in `sec_ctl` never fails.
- R9: Secondary checking is gated by bit 31 of `pri_ctl`. When that bit is 0, `rsp_sec_mask` is 0 whatever the secondary inputs.
- R10: `rsp_pri_fail` is the OR of `rsp_pri_mask`. `rsp_sec_fail` is the OR of `rsp_sec_mask`. `rsp_fail` is the OR of the two flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| basic_cap | input | 64 | Basic capability word; bit 55 selects the encoding |
| legacy_cap | input | 64 | Legacy primary capability word |
| true_cap | input | 64 | True primary capability word |
| sec_cap | input | 64 | Secondary capability word |
| pri_ctl | input | 32 | Proposed primary control word |
| sec_ctl | input | 32 | Proposed secondary control word |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fail | output | 1 | Overall verdict: 1 = entry refused |
| rsp_pri_fail | output | 1 | Primary word has a violation |
| rsp_sec_fail | output | 1 | Secondary word has a violation |
| rsp_pri_mask | output | 32 | Per-bit primary violations |
| rsp_sec_mask | output | 32 | Per-bit secondary violations |

## Verification
The hardest case to reach is a single bit that fails for one reason only while the other 31 bits stay clean. Random words almost always make many bits fail at once, which hides a fault in one bit or in one rule. The bench therefore sweeps every bit position through all eight combinations of control bit, required-1 bit and allowed-1 bit, in both encodings. The neutral bits are set so they cannot fail. In the legacy sweep the default-1 bits are held at 1, and `true_cap` is filled with opposing values to show that it has no effect. The secondary sweep does the same with the gate on, using a random low half in `sec_cap`, and then repeats the stimulus with the gate off.

// File: rtl/vmcc_pkg.sv
package vmcc_pkg;
  localparam int unsigned CTL_W = 32;
  localparam logic [CTL_W-1:0] DEF1_MASK_DEFAULT = 32'h0401_E172;

  typedef struct packed {
    logic [CTL_W-1:0] pri;
    logic [CTL_W-1:0] sec;
  } viol_t;
endpackage

// File: rtl/vmcc_bit_check.sv
module vmcc_bit_check #(
  parameter int unsigned W = 32,
  parameter bit HAS_REQ1 = 1'b1
) (
  input  logic [W-1:0] ctl,
  input  logic [W-1:0] need_one,
  input  logic [W-1:0] may_one,
  input  logic         enable,
  output logic [W-1:0] viol
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bad_zero;
    logic bad_one;
    if (HAS_REQ1) begin : g_req
      assign bad_zero = need_one[i] & ~ctl[i];
    end else begin : g_noreq
      assign bad_zero = 1'b0;
    end
    assign bad_one = ctl[i] & ~may_one[i];
    assign viol[i] = enable & (bad_zero | bad_one);
  end

  logic unused_need;
  assign unused_need = HAS_REQ1 ? 1'b0 : ^need_one;
endmodule

// File: rtl/vmcc_cap_select.sv
module vmcc_cap_select #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] DEF1_MASK = '0
) (
  input  logic         use_true,
  input  logic [2*W-1:0] legacy_cap,
  input  logic [2*W-1:0] true_cap,
  output logic [W-1:0] need_one,
  output logic [W-1:0] may_one
);
  always_comb begin
    if (use_true) begin
      need_one = true_cap[W-1:0];
      may_one  = true_cap[2*W-1:W];
    end else begin
      need_one = legacy_cap[W-1:0] | DEF1_MASK;
      may_one  = legacy_cap[2*W-1:W];
    end
  end
endmodule

// File: rtl/vmcc_rsp_reg.sv
module vmcc_rsp_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         accept,
  input  logic [W-1:0] pri_d,
  input  logic [W-1:0] sec_d,
  output logic         rsp_valid,
  output logic         rsp_fail,
  output logic         rsp_pri_fail,
  output logic         rsp_sec_fail,
  output logic [W-1:0] rsp_pri_mask,
  output logic [W-1:0] rsp_sec_mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_fail     <= 1'b0;
      rsp_pri_fail <= 1'b0;
      rsp_sec_fail <= 1'b0;
      rsp_pri_mask <= '0;
      rsp_sec_mask <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_pri_mask <= pri_d;
        rsp_sec_mask <= sec_d;
        rsp_pri_fail <= |pri_d;
        rsp_sec_fail <= |sec_d;
        rsp_fail     <= (|pri_d) | (|sec_d);
      end
    end
  end

  // R2
  accept_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> rsp_valid);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> (!rsp_valid && $stable(rsp_pri_mask) && $stable(rsp_sec_mask)));
  // R10
  fail_or_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fail == ((|rsp_pri_mask) || (|rsp_sec_mask))));
endmodule

// File: rtl/vmctl_cap_check.sv
module vmctl_cap_check #(
  parameter int unsigned CTL_W    = vmcc_pkg::CTL_W,
  parameter int unsigned MODE_BIT = 55,
  parameter int unsigned GATE_BIT = 31,
  parameter logic [CTL_W-1:0] DEF1_MASK = vmcc_pkg::DEF1_MASK_DEFAULT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2*CTL_W-1:0] basic_cap,
  input  logic [2*CTL_W-1:0] legacy_cap,
  input  logic [2*CTL_W-1:0] true_cap,
  input  logic [2*CTL_W-1:0] sec_cap,
  input  logic [CTL_W-1:0]   pri_ctl,
  input  logic [CTL_W-1:0]   sec_ctl,
  output logic               rsp_valid,
  output logic               rsp_fail,
  output logic               rsp_pri_fail,
  output logic               rsp_sec_fail,
  output logic [CTL_W-1:0]   rsp_pri_mask,
  output logic [CTL_W-1:0]   rsp_sec_mask
);
  localparam int unsigned CAP_W = 2 * CTL_W;

  logic              accept;
  logic              use_true;
  logic              sec_on;
  logic [CTL_W-1:0]  need_one;
  logic [CTL_W-1:0]  may_one;
  vmcc_pkg::viol_t   viol;

  always_ff @(posedge clk) begin
    if (rst) req_ready <= 1'b0;
    else     req_ready <= 1'b1;
  end

  assign accept   = req_valid & req_ready;
  assign use_true = basic_cap[MODE_BIT];
  assign sec_on   = pri_ctl[GATE_BIT];

  vmcc_cap_select #(.W(CTL_W), .DEF1_MASK(DEF1_MASK)) u_sel (
    .use_true  (use_true),
    .legacy_cap(legacy_cap),
    .true_cap  (true_cap),
    .need_one  (need_one),
    .may_one   (may_one)
  );

  vmcc_bit_check #(.W(CTL_W), .HAS_REQ1(1'b1)) u_pri (
    .ctl     (pri_ctl),
    .need_one(need_one),
    .may_one (may_one),
    .enable  (1'b1),
    .viol    (viol.pri)
  );

  vmcc_bit_check #(.W(CTL_W), .HAS_REQ1(1'b0)) u_sec (
    .ctl     (sec_ctl),
    .need_one(sec_cap[CTL_W-1:0]),
    .may_one (sec_cap[CAP_W-1:CTL_W]),
    .enable  (sec_on),
    .viol    (viol.sec)
  );

  vmcc_rsp_reg #(.W(CTL_W)) u_rsp (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .pri_d       (viol.pri),
    .sec_d       (viol.sec),
    .rsp_valid   (rsp_valid),
    .rsp_fail    (rsp_fail),
    .rsp_pri_fail(rsp_pri_fail),
    .rsp_sec_fail(rsp_sec_fail),
    .rsp_pri_mask(rsp_pri_mask),
    .rsp_sec_mask(rsp_sec_mask)
  );

  logic unused_basic;
  assign unused_basic = ^basic_cap;

  // R9
  sec_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !pri_ctl[GATE_BIT]) |=> (rsp_sec_mask == '0));
  // R6
  legacy_def1_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !basic_cap[MODE_BIT]) |=>
      ((rsp_pri_mask & $past(~pri_ctl & DEF1_MASK)) == $past(~pri_ctl & DEF1_MASK)));
  // R4
  true_forbid_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && basic_cap[MODE_BIT]) |=>
      ((rsp_pri_mask & $past(pri_ctl & ~true_cap[CAP_W-1:CTL_W]))
        == $past(pri_ctl & ~true_cap[CAP_W-1:CTL_W])));
endmodule

// File: tb/vmctl_cap_check_test.sv
module vmctl_cap_check_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DEF1 = 32'h0401_E172;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] basic_cap = '0, legacy_cap = '0, true_cap = '0, sec_cap = '0;
  logic [31:0] pri_ctl = '0, sec_ctl = '0;
  logic        rsp_valid, rsp_fail, rsp_pri_fail, rsp_sec_fail;
  logic [31:0] rsp_pri_mask, rsp_sec_mask;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  vmctl_cap_check uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .basic_cap(basic_cap), .legacy_cap(legacy_cap), .true_cap(true_cap),
    .sec_cap(sec_cap), .pri_ctl(pri_ctl), .sec_ctl(sec_ctl),
    .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .rsp_pri_fail(rsp_pri_fail),
    .rsp_sec_fail(rsp_sec_fail), .rsp_pri_mask(rsp_pri_mask),
    .rsp_sec_mask(rsp_sec_mask)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pri();
    logic [31:0] r;
    bit tmode = basic_cap[55];
    for (int i = 0; i < 32; i++) begin
      bit need = tmode ? true_cap[i] : (legacy_cap[i] || DEF1[i]);
      bit may  = tmode ? true_cap[32+i] : legacy_cap[32+i];
      r[i] = pri_ctl[i] ? !may : need;
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_sec();
    logic [31:0] r = '0;
    if (pri_ctl[31])
      for (int i = 0; i < 32; i++) r[i] = sec_ctl[i] && !sec_cap[32+i];
    return r;
  endfunction

  task automatic run_req(input string tag);
    logic [31:0] ep, es;
    ep = exp_pri();
    es = exp_sec();
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R2 rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
    chk({tag, " pri mask"}, rsp_pri_mask, ep);
    chk({tag, " sec mask"}, rsp_sec_mask, es);
    chk({tag, " R10 flags"}, {29'b0, rsp_fail, rsp_pri_fail, rsp_sec_fail},
        {29'b0, (|ep) || (|es), |ep, |es});
    @(negedge clk);
    chk({tag, " R2 pulse end"}, {31'b0, rsp_valid}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready in reset", {31'b0, req_ready}, 32'd0);
    chk("R1 valid in reset", {31'b0, rsp_valid}, 32'd0);
    chk("R1 masks in reset", rsp_pri_mask | rsp_sec_mask, 32'd0);
    chk("R1 flags in reset", {29'b0, rsp_fail, rsp_pri_fail, rsp_sec_fail}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", {31'b0, req_ready}, 32'd1);

    // R3 R4 R7: per-bit sweep, true encoding, legacy word hostile
    for (int x = 0; x < 32; x++) begin
      for (int c = 0; c < 8; c++) begin
        basic_cap  = 64'h0080_0000_0000_0000;
        legacy_cap = 64'h0000_0000_FFFF_FFFF;
        true_cap   = {32'hFFFF_FFFF, 32'h0};
        pri_ctl    = '0;
        sec_ctl    = '0;
        sec_cap    = '1;
        pri_ctl[x]     = c[0];
        true_cap[x]    = c[1];
        true_cap[32+x] = c[2];
        run_req("R3/R4/R5/R7 true sweep");
      end
    end

    // R6: per-bit sweep, legacy encoding, default-1 bits held at 1
    for (int x = 0; x < 32; x++) begin
      for (int c = 0; c < 8; c++) begin
        basic_cap  = next_rand() & ~64'h0080_0000_0000_0000;
        true_cap   = 64'h0000_0000_FFFF_FFFF;
        legacy_cap = {32'hFFFF_FFFF, 32'h0};
        pri_ctl    = DEF1;
        sec_ctl    = '0;
        sec_cap    = '1;
        pri_ctl[x]       = c[0];
        legacy_cap[x]    = c[1];
        legacy_cap[32+x] = c[2];
        run_req("R6 legacy sweep");
      end
    end

    // R7: zero control word in true mode with no requirements passes
    basic_cap = 64'h0080_0000_0000_0000;
    true_cap = '0; legacy_cap = 64'hFFFF_FFFF_FFFF_FFFF;
    pri_ctl = '0; sec_ctl = '0;
    run_req("R7 no default-1 in true mode");
    chk("R7 pass", {31'b0, rsp_fail}, 32'd0);

    // R8: secondary sweep, gate on, low half random
    for (int x = 0; x < 32; x++) begin
      for (int c = 0; c < 4; c++) begin
        basic_cap = 64'h0080_0000_0000_0000;
        true_cap  = {32'hFFFF_FFFF, 32'h0};
        pri_ctl   = 32'h8000_0000;
        sec_ctl   = '0;
        sec_cap   = {32'hFFFF_FFFF, next_rand() >> 32};
        sec_ctl[x]     = c[0];
        sec_cap[32+x]  = c[1];
        run_req("R8 secondary sweep");
      end
    end

    // R9: gate off, secondary inputs hostile
    for (int x = 0; x < 32; x++) begin
      basic_cap = 64'h0080_0000_0000_0000;
      true_cap  = {32'hFFFF_FFFF, 32'h0};
      pri_ctl   = 32'h0000_0000;
      sec_ctl   = 32'hFFFF_FFFF;
      sec_cap   = next_rand() & 64'h0000_0000_FFFF_FFFF;
      sec_cap[32+x] = 1'b1;
      run_req("R9 gate off");
      chk("R9 sec fail low", {31'b0, rsp_sec_fail}, 32'd0);
    end

    // R2: no accept when valid low; outputs hold
    pri_ctl = 32'h1234_5678; true_cap = '0;
    repeat (3) begin
      @(negedge clk);
      chk("R2 idle no response", {31'b0, rsp_valid}, 32'd0);
      chk("R2 idle mask hold", rsp_sec_mask, 32'd0);
    end

    // R10: random mixed requests
    for (int n = 0; n < 200; n++) begin
      basic_cap  = next_rand();
      legacy_cap = next_rand() | next_rand();
      true_cap   = next_rand() | next_rand();
      sec_cap    = next_rand() | next_rand();
      pri_ctl    = next_rand() >> 32;
      sec_ctl    = next_rand() >> 32;
      if (n % 4 == 0) begin
        legacy_cap = {32'hFFFF_FFFF, legacy_cap[31:0] & pri_ctl};
        true_cap   = {32'hFFFF_FFFF, true_cap[31:0] & pri_ctl};
        sec_cap    = {32'hFFFF_FFFF, sec_cap[31:0]};
        pri_ctl    = pri_ctl | DEF1;
      end
      run_req("R10 random");
    end

    // R1: reset mid-run clears results
    pri_ctl = '0; basic_cap = '0; legacy_cap = '0;
    run_req("R1 pre-reset");
    rst = 1'b1;
    @(negedge clk);
    chk("R1 masks cleared", rsp_pri_mask | rsp_sec_mask, 32'd0);
    chk("R1 fail cleared", {31'b0, rsp_fail}, 32'd0);
    chk("R1 ready cleared", {31'b0, req_ready}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule